// File: doc/BRIEF.md
# Single-Mode DMA Transfer Engine

This block moves data for one DMA channel at a time. It holds a small set of registers for each channel: a mode byte, a mask bit, a base address and base count, and the current address and count. A requester names a channel and asks for a number of elements. The engine accepts the request only when the channel is unmasked, its mode byte selects single mode, and its transfer type is legal. It then moves the smaller of the requested length and the channel's remaining count.

Each element is one memory access on a valid/ready port. The access is a write to memory, a read from memory, or no access at all for verify. After each element the current address steps up or down and the current count drops by one. The element size is a byte in the lower half of the channels and a 16-bit word in the upper half. When the engine finishes, it raises a one-cycle done pulse together with the number of elements it moved.

When a channel's count reaches zero, its terminal-count flag is set. The channel then either reloads from its base registers or masks itself. Configuration is written through a narrow write port while the engine is idle. A read port shows the current address and count of any channel.

Top module: `dma_single_engine`

## Requirements
- R1: After reset every channel is masked, all terminal-count flags are clear, all current addresses and counts read 0, `req_ready` is 1 and `mem_valid` is 0.
- R2: A request accepted on a channel whose mask bit is 1 produces `done` = 1 with `done_count` = 0 in the next cycle, and changes no channel state.
- R3: Mode byte bits 7:6 select the operating mode, where 01 is single. A request on any other value (00, 10, 11) produces `done` with `done_count` = 0 in the next cycle and no memory access.
- R4: Mode byte bits 3:2 select the transfer type: 00 verify, 01 write to memory, 10 read from memory. The value 11 is illegal and produces `done` with `done_count` = 0 in the next cycle. A request of length 0, or on a channel whose count is 0, ends the same way.
- R5: A valid request moves n = min(`req_len`, current count) elements. `done` pulses with `done_count` = n in the cycle after the n-th element is taken.
- R6: Mode bit 5 = 0 makes the address step up after each element, and bit 5 = 1 makes it step down. The step is 1 for channels 0 to NCH/2-1 and 2 for channels NCH/2 to NCH-1 (`mem_word` = 1). `mem_addr` is the current address before the step.
- R7: For type 01, `mem_write` = 1 and `mem_wdata` carries `dev_wdata`, with the upper byte zeroed on byte channels. For type 10, `mem_write` = 0 and each accepted access returns `mem_rdata` on `dev_rdata`, with `dev_rvalid` = 1 one cycle later and the upper byte zeroed on byte channels.
- R8: A verify transfer (type 00) keeps `mem_valid` at 0. It takes one element per cycle and updates the address and count exactly as a real transfer does.
- R9: When the current count reaches 0, the channel's terminal-count flag is set. If mode bit 4 is 1, the current address and count reload from the base values. Otherwise the channel's mask bit is set.
- R10: `req_ready` is 0 from the cycle after a transfer is accepted until it ends. While `mem_valid` = 1 and `mem_ready` = 0, `mem_valid`, `mem_addr` and `mem_write` hold.
- R11: When `cfg_we` = 1 and the engine is idle, `cfg_field` selects the target. 0 writes the mode byte from `cfg_data[7:0]`. 1 writes the base and current address. 2 writes the base and current count and clears the terminal-count flag. 3 writes the mask bit from `cfg_data[0]`. Configuration writes made while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_chan | input | CHW | Channel to configure |
| cfg_field | input | 2 | Field select: 0 mode, 1 address, 2 count, 3 mask |
| cfg_data | input | AW | Configuration data |
| req_valid | input | 1 | Transfer request |
| req_ready | output | 1 | Engine idle, request accepted |
| req_chan | input | CHW | Requested channel |
| req_len | input | CW | Requested element count |
| done | output | 1 | One-cycle completion pulse |
| done_count | output | CW | Elements moved, valid with done |
| mem_valid | output | 1 | Memory access request |
| mem_ready | input | 1 | Memory access accepted |
| mem_write | output | 1 | 1 writes memory, 0 reads |
| mem_word | output | 1 | 1 for a 16-bit element, 0 for a byte |
| mem_addr | output | AW | Access address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, taken on handshake |
| dev_wdata | input | DW | Device data to store to memory |
| dev_rvalid | output | 1 | Read element delivered |
| dev_rdata | output | DW | Read element data |
| rd_chan | input | CHW | Channel shown on the read port |
| rd_addr | output | AW | Current address of rd_chan |
| rd_count | output | CW | Current count of rd_chan |
| mask_flags | output | NCH | Mask bit per channel |
| tc_flags | output | NCH | Terminal-count flag per channel |

## Verification
A wrong channel index or a wrong stored count shows up at once: `mem_addr` is wrong on the first access, or `done_count` is wrong in the cycle after the last element. A wrong step direction or size is visible on the second access of a transfer. A missed reload or a missed mask is visible on `rd_addr`, `rd_count` and `mask_flags` within one read-port cycle of the done pulse. It also shows when the next request on that channel is wrongly accepted or rejected. A stuck busy state keeps `req_ready` low, and a reference model compared every cycle catches that in the first cycle it diverges.

// File: rtl/dma_single_engine.sv
module dma_single_engine #(
  parameter int NCH = 8,
  parameter int AW  = 24,
  parameter int CW  = 16,
  parameter int DW  = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [$clog2(NCH)-1:0] cfg_chan,
  input  logic [1:0]      cfg_field,
  input  logic [AW-1:0]   cfg_data,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [$clog2(NCH)-1:0] req_chan,
  input  logic [CW-1:0]   req_len,
  output logic            done,
  output logic [CW-1:0]   done_count,
  output logic            mem_valid,
  input  logic            mem_ready,
  output logic            mem_write,
  output logic            mem_word,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  input  logic [DW-1:0]   dev_wdata,
  output logic            dev_rvalid,
  output logic [DW-1:0]   dev_rdata,
  input  logic [$clog2(NCH)-1:0] rd_chan,
  output logic [AW-1:0]   rd_addr,
  output logic [CW-1:0]   rd_count,
  output logic [NCH-1:0]  mask_flags,
  output logic [NCH-1:0]  tc_flags
);
  localparam int CHW = $clog2(NCH);
  localparam logic [CW-1:0] ONE_C = CW'(1);

  logic [7:0]    mode_q     [NCH];
  logic [AW-1:0] base_addr_q[NCH];
  logic [AW-1:0] cur_addr_q [NCH];
  logic [CW-1:0] base_cnt_q [NCH];
  logic [CW-1:0] cur_cnt_q  [NCH];
  logic [NCH-1:0] mask_q, tc_q;

  logic           busy_q, done_q, rvalid_q;
  logic [CHW-1:0] chan_q;
  logic [CW-1:0]  left_q, total_q, done_cnt_q;
  logic [DW-1:0]  rdata_q;

  logic [7:0]    req_mode, act_mode;
  logic [CW-1:0] req_cnt, req_n, next_c;
  logic          req_ok, act_word, step, last;
  logic [1:0]    act_type;
  logic [AW-1:0] cur_a, step_sz, next_a;

  assign req_mode = mode_q[req_chan];
  assign req_cnt  = cur_cnt_q[req_chan];
  assign req_n    = (req_len < req_cnt) ? req_len : req_cnt;
  assign req_ok   = !mask_q[req_chan] && (req_mode[7:6] == 2'b01) &&
                    (req_mode[3:2] != 2'b11) && (req_n != '0);

  assign act_mode = mode_q[chan_q];
  assign act_type = act_mode[3:2];
  assign act_word = chan_q[CHW-1];
  assign step     = busy_q && ((act_type == 2'b00) || mem_ready);
  assign last     = step && (left_q == ONE_C);
  assign cur_a    = cur_addr_q[chan_q];
  assign step_sz  = {{(AW-2){1'b0}}, act_word, ~act_word};
  assign next_a   = act_mode[5] ? cur_a - step_sz : cur_a + step_sz;
  assign next_c   = cur_cnt_q[chan_q] - ONE_C;

  assign req_ready  = !busy_q;
  assign mem_valid  = busy_q && (act_type != 2'b00);
  assign mem_write  = (act_type == 2'b01);
  assign mem_word   = act_word;
  assign mem_addr   = cur_a;
  assign mem_wdata  = act_word ? dev_wdata : {{(DW-8){1'b0}}, dev_wdata[7:0]};
  assign done       = done_q;
  assign done_count = done_cnt_q;
  assign dev_rvalid = rvalid_q;
  assign dev_rdata  = rdata_q;
  assign rd_addr    = cur_addr_q[rd_chan];
  assign rd_count   = cur_cnt_q[rd_chan];
  assign mask_flags = mask_q;
  assign tc_flags   = tc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        mode_q[i]      <= '0;
        base_addr_q[i] <= '0;
        cur_addr_q[i]  <= '0;
        base_cnt_q[i]  <= '0;
        cur_cnt_q[i]   <= '0;
      end
      mask_q     <= '1;
      tc_q       <= '0;
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      rvalid_q   <= 1'b0;
      chan_q     <= '0;
      left_q     <= '0;
      total_q    <= '0;
      done_cnt_q <= '0;
      rdata_q    <= '0;
    end else begin
      done_q   <= 1'b0;
      rvalid_q <= 1'b0;
      if (!busy_q) begin
        if (cfg_we) begin
          case (cfg_field)
            2'd0: mode_q[cfg_chan] <= cfg_data[7:0];
            2'd1: begin
              base_addr_q[cfg_chan] <= cfg_data;
              cur_addr_q[cfg_chan]  <= cfg_data;
            end
            2'd2: begin
              base_cnt_q[cfg_chan] <= cfg_data[CW-1:0];
              cur_cnt_q[cfg_chan]  <= cfg_data[CW-1:0];
              tc_q[cfg_chan]       <= 1'b0;
            end
            default: mask_q[cfg_chan] <= cfg_data[0];
          endcase
        end
        if (req_valid) begin
          if (req_ok) begin
            busy_q  <= 1'b1;
            chan_q  <= req_chan;
            left_q  <= req_n;
            total_q <= req_n;
          end else begin
            done_q     <= 1'b1;
            done_cnt_q <= '0;
          end
        end
      end else if (step) begin
        cur_addr_q[chan_q] <= next_a;
        cur_cnt_q[chan_q]  <= next_c;
        left_q             <= left_q - ONE_C;
        if (act_type == 2'b10) begin
          rvalid_q <= 1'b1;
          rdata_q  <= act_word ? mem_rdata : {{(DW-8){1'b0}}, mem_rdata[7:0]};
        end
        if (last) begin
          busy_q     <= 1'b0;
          done_q     <= 1'b1;
          done_cnt_q <= total_q;
          if (next_c == '0) begin
            tc_q[chan_q] <= 1'b1;
            if (act_mode[4]) begin
              cur_addr_q[chan_q] <= base_addr_q[chan_q];
              cur_cnt_q[chan_q]  <= base_cnt_q[chan_q];
            end else begin
              mask_q[chan_q] <= 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/dma_single_engine_chk.sv
module dma_single_engine_chk #(
  parameter int NCH = 8,
  parameter int AW  = 24,
  parameter int CW  = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic                   req_ready,
  input logic [$clog2(NCH)-1:0] req_chan,
  input logic [7:0]             req_mode,
  input logic [NCH-1:0]         mask_flags,
  input logic                   done,
  input logic [CW-1:0]          done_count,
  input logic                   mem_valid,
  input logic                   mem_ready,
  input logic                   mem_write,
  input logic [AW-1:0]          mem_addr,
  input logic                   dev_rvalid
);
  AST_MASKED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && mask_flags[req_chan] |=> done && done_count == '0); // R2
  AST_NOT_SINGLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_mode[7:6] != 2'b01 |=> done && done_count == '0 && !mem_valid); // R3
  AST_ILLEGAL_TYPE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_mode[3:2] == 2'b11 |=> done && done_count == '0); // R4
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_write)); // R10
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !req_ready); // R10
  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rvalid |-> $past(mem_valid && mem_ready && !mem_write)); // R7
endmodule

bind dma_single_engine dma_single_engine_chk #(.NCH(NCH), .AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_chan(req_chan), .req_mode(req_mode), .mask_flags(mask_flags),
  .done(done), .done_count(done_count), .mem_valid(mem_valid),
  .mem_ready(mem_ready), .mem_write(mem_write), .mem_addr(mem_addr),
  .dev_rvalid(dev_rvalid)
);

// File: tb/dma_single_engine_bench.sv
`timescale 1ns/1ps
module dma_single_engine_bench;
  localparam int NCH = 8, AW = 24, CW = 16, DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_chan = '0;
  logic [1:0] cfg_field = '0;
  logic [AW-1:0] cfg_data = '0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [2:0] req_chan = '0;
  logic [CW-1:0] req_len = '0;
  logic done;
  logic [CW-1:0] done_count;
  logic mem_valid, mem_write, mem_word;
  logic mem_ready = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic [DW-1:0] dev_wdata = '0;
  logic dev_rvalid;
  logic [DW-1:0] dev_rdata;
  logic [2:0] rd_chan = '0;
  logic [AW-1:0] rd_addr;
  logic [CW-1:0] rd_count;
  logic [NCH-1:0] mask_flags, tc_flags;

  always #2.5 clk = ~clk;

  dma_single_engine #(.NCH(NCH), .AW(AW), .CW(CW), .DW(DW)) u_dma_single_engine (.*);

  int checks = 0, errors = 0, cyc = 0, stall = 0, last_dc = -1;
  bit armed = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_mode[NCH], m_ba[NCH], m_ca[NCH], m_bc[NCH], m_cc[NCH];
  bit m_mask[NCH], m_tc[NCH];
  bit m_busy, m_done, m_rv;
  int m_ch, m_rem, m_n, m_dc, m_rd;

  always @(posedge clk) begin
    m_done = 0; m_rv = 0;
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        m_mode[i] = 0; m_ba[i] = 0; m_ca[i] = 0; m_bc[i] = 0; m_cc[i] = 0;
        m_mask[i] = 1; m_tc[i] = 0;
      end
      m_busy = 0; m_dc = 0;
    end else if (m_busy) begin
      int t, sz;
      t = (m_mode[m_ch] >> 2) & 3;
      if (t == 0 || mem_ready) begin
        sz = (m_ch >= NCH/2) ? 2 : 1;
        if (t == 2) begin
          m_rv = 1;
          m_rd = (m_ch >= NCH/2) ? int'(mem_rdata) : int'(mem_rdata) & 255;
        end
        if ((m_mode[m_ch] & 32) != 0) m_ca[m_ch] = (m_ca[m_ch] - sz) & 24'hFFFFFF;
        else m_ca[m_ch] = (m_ca[m_ch] + sz) & 24'hFFFFFF;
        m_cc[m_ch]--; m_rem--;
        if (m_rem == 0) begin
          m_busy = 0; m_done = 1; m_dc = m_n;
          if (m_cc[m_ch] == 0) begin
            m_tc[m_ch] = 1;
            if ((m_mode[m_ch] & 16) != 0) begin
              m_ca[m_ch] = m_ba[m_ch]; m_cc[m_ch] = m_bc[m_ch];
            end else m_mask[m_ch] = 1;
          end
        end
      end
    end else begin
      if (req_valid) begin
        int md, n;
        md = m_mode[req_chan];
        n = (int'(req_len) < m_cc[req_chan]) ? int'(req_len) : m_cc[req_chan];
        if (!m_mask[req_chan] && ((md >> 6) & 3) == 1 && ((md >> 2) & 3) != 3 && n > 0) begin
          m_busy = 1; m_ch = req_chan; m_rem = n; m_n = n;
        end else begin
          m_done = 1; m_dc = 0;
        end
      end
      if (cfg_we) begin
        case (cfg_field)
          2'd0: m_mode[cfg_chan] = cfg_data[7:0];
          2'd1: begin m_ba[cfg_chan] = cfg_data; m_ca[cfg_chan] = cfg_data; end
          2'd2: begin m_bc[cfg_chan] = cfg_data[15:0]; m_cc[cfg_chan] = cfg_data[15:0]; m_tc[cfg_chan] = 0; end
          default: m_mask[cfg_chan] = cfg_data[0];
        endcase
      end
    end
  end

  // stimulus for the memory side and read port
  always @(posedge clk) rd_chan <= rd_chan + 3'd1;
  always @(negedge clk) begin
    cyc++;
    if (stall > 0) stall--;
    mem_ready <= (stall == 0) && (cyc % 3 != 1);
    mem_rdata <= 16'hA500 + 16'(cyc);
    dev_wdata <= 16'h3C00 + 16'(cyc * 7);
  end

  // per-cycle comparison with the model
  always @(negedge clk) begin
    if (armed) begin
      int t, mv, mk, tc;
      t = (m_mode[m_ch] >> 2) & 3;
      mv = (m_busy && t != 0) ? 1 : 0;
      mk = 0; tc = 0;
      for (int i = 0; i < NCH; i++) begin
        mk |= int'(m_mask[i]) << i;
        tc |= int'(m_tc[i]) << i;
      end
      chk(req_ready == !m_busy, "R10 req_ready", int'(req_ready), int'(!m_busy));
      chk(mem_valid == mv[0], "R8 mem_valid", int'(mem_valid), mv);
      if (mv != 0) begin
        chk(int'(mem_addr) == m_ca[m_ch], "R6 mem_addr", int'(mem_addr), m_ca[m_ch]);
        chk(mem_write == (t == 1), "R7 mem_write", int'(mem_write), int'(t == 1));
        chk(mem_word == (m_ch >= NCH/2), "R6 mem_word", int'(mem_word), int'(m_ch >= NCH/2));
        if (t == 1) begin
          int w;
          w = (m_ch >= NCH/2) ? int'(dev_wdata) : int'(dev_wdata) & 255;
          chk(int'(mem_wdata) == w, "R7 mem_wdata", int'(mem_wdata), w);
        end
      end
      chk(done == m_done, "R5 done", int'(done), int'(m_done));
      if (m_done) chk(int'(done_count) == m_dc, "R5 done_count", int'(done_count), m_dc);
      chk(dev_rvalid == m_rv, "R7 dev_rvalid", int'(dev_rvalid), int'(m_rv));
      if (m_rv) chk(int'(dev_rdata) == m_rd, "R7 dev_rdata", int'(dev_rdata), m_rd);
      chk(int'(rd_addr) == m_ca[rd_chan], "R6 rd_addr", int'(rd_addr), m_ca[rd_chan]);
      chk(int'(rd_count) == m_cc[rd_chan], "R9 rd_count", int'(rd_count), m_cc[rd_chan]);
      chk(int'(mask_flags) == mk, "R9 mask_flags", int'(mask_flags), mk);
      chk(int'(tc_flags) == tc, "R9 tc_flags", int'(tc_flags), tc);
      if (done) last_dc = int'(done_count);
    end
  end

  task automatic cfg(input int ch, input int fld, input int data);
    @(negedge clk);
    cfg_we = 1; cfg_chan = 3'(ch); cfg_field = 2'(fld); cfg_data = AW'(data);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic setup(input int ch, input int mode, input int addr, input int cnt);
    cfg(ch, 0, mode); cfg(ch, 1, addr); cfg(ch, 2, cnt); cfg(ch, 3, 0);
  endtask

  task automatic req(input int ch, input int len);
    @(negedge clk);
    req_valid = 1; req_chan = 3'(ch); req_len = CW'(len);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_idle();
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic peek(input int ch, input int a, input int c, input string tag);
    while (int'(rd_chan) != ch) @(negedge clk);
    chk(int'(rd_addr) == a, tag, int'(rd_addr), a);
    chk(int'(rd_count) == c, tag, int'(rd_count), c);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; armed = 1;
    @(negedge clk);
    chk(mask_flags == '1 && tc_flags == '0, "R1 reset flags", int'(mask_flags), 255);
    chk(req_ready && !mem_valid, "R1 reset handshake", int'(mem_valid), 0);
    peek(3, 0, 0, "R1 reset regs");

    req(0, 4); wait_idle();
    chk(last_dc == 0, "R2 masked request", last_dc, 0);

    setup(1, 'h44, 'h1000, 5);
    req(1, 3); wait_idle();
    chk(last_dc == 3, "R5 min by length", last_dc, 3);
    peek(1, 'h1003, 2, "R6 increment byte");
    req(1, 10); wait_idle();
    chk(last_dc == 2, "R5 min by count", last_dc, 2);
    chk(mask_flags[1] && tc_flags[1], "R9 mask on terminal", int'(mask_flags[1]), 1);

    setup(5, 'h78, 'h2000, 4);
    req(5, 6); wait_idle();
    chk(last_dc == 4, "R7 read word count", last_dc, 4);
    chk(tc_flags[5] && !mask_flags[5], "R9 autoinit keeps unmasked", int'(mask_flags[5]), 0);
    peek(5, 'h2000, 4, "R9 autoinit reload");

    setup(2, 'h40, 'h300, 6);
    req(2, 4); wait_idle();
    chk(last_dc == 4, "R8 verify count", last_dc, 4);
    peek(2, 'h304, 2, "R8 verify updates");

    setup(3, 'h04, 'h50, 3);
    req(3, 2); wait_idle();
    chk(last_dc == 0, "R3 demand rejected", last_dc, 0);
    cfg(3, 0, 'h84); req(3, 2); wait_idle();
    chk(last_dc == 0, "R3 block rejected", last_dc, 0);
    cfg(3, 0, 'hC4); req(3, 2); wait_idle();
    chk(last_dc == 0, "R3 cascade rejected", last_dc, 0);
    cfg(3, 0, 'h4C); req(3, 2); wait_idle();
    chk(last_dc == 0, "R4 illegal type", last_dc, 0);
    peek(3, 'h50, 3, "R4 no state change");
    req(2, 0); wait_idle();
    chk(last_dc == 0, "R4 zero length", last_dc, 0);

    setup(6, 'h64, 'h4000, 3);
    stall = 6;
    req(6, 3);
    cfg(2, 1, 'h999);
    req(2, 1); wait_idle();
    peek(6, 'h3FFA, 0, "R10 word decrement under stall");
    peek(2, 'h305, 1, "R11 busy cfg ignored");
    cfg(6, 2, 5);
    chk(!tc_flags[6], "R11 count write clears tc", int'(tc_flags[6]), 0);

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule